// File: doc/BRIEF.md
# Descriptor-Ring Receive DMA

This block moves incoming byte frames into memory through a ring of descriptor tables. Software picks a base address for the tables, the number of tables in the ring (written as count minus one), and how many 16-byte descriptors each table holds (also written as count minus one). It then arms the engine and advances a write pointer as it frees tables. Each frame uses exactly one table. The engine fetches that table's descriptors one at a time and places the frame's bytes into the region each descriptor names.

When a frame finishes, or the table runs out of room, the engine writes the stored byte count and a completion code back to the descriptor where writing stopped. It then advances its read pointer. This pointer counts through the ring and flips its top bit on every wrap. The engine also sets a sticky end-of-frame flag, which software clears by writing a one. If a frame arrives while the ring has no free table, the engine discards the frame and sets a sticky overflow flag.

Memory is reached through three ports, each with a valid/ready handshake: a descriptor fetch port, a byte write port and a descriptor status write-back port. A fetch response arrives as a single valid pulse.

Top module: `prd_ring_rxdma`

## Requirements
- R1: After reset, rd_ptr is 00h, eof_sts, ovf_sts and irq are 0, and in_ready, mw_valid, dreq_valid and wb_valid are all low.
- R2: Entry k of table n is fetched from cfg_base + (n × (cfg_ents_m1+1) + k) × 16. Here n is rd_ptr[6:0]. The entries of a table are fetched in order, starting at k = 0.
- R3: In a fetched 128-bit entry, bits 53:0 give the destination byte address, bits 87:64 give the byte length and bit 88 marks the end of the table. The i-th byte stored in an entry goes to destination + i. Bytes keep the order in which they arrived, and no byte is written unless it is accepted from the input.
- R4: rd_ptr[6:0] counts from 0 up to cfg_depth_m1 and then returns to 0 with rd_ptr[7] inverted. With cfg_depth_m1 = 3, the sequence is 00h, 01h, 02h, 03h, 80h, 81h, 82h, 83h, 00h.
- R5: An entry is the last of its table when its end bit is set or when k = cfg_ents_m1. If a frame fills the last entry before its final byte, the remaining bytes are accepted and discarded. The status write-back then reports that entry's length with code 10b.
- R6: When a frame's final byte lands in an entry, that entry's address is written back with the number of bytes stored in it and code 01b. Filling an entry that is not the last moves the frame on to the next entry.
- R7: Each completed frame advances rd_ptr by one step and sets eof_sts. eof_sts stays set until a cycle with eof_clr high. If both happen in the same cycle, the set wins.
- R8: irq is high exactly while eof_sts and cfg_eof_ie are both 1.
- R9: The ring is full when rd_ptr[6:0] equals sw_wptr[6:0] and bit 7 of the two differs. A frame that starts while the ring is full is discarded with no memory write and no pointer change. It sets ovf_sts, which stays set until ovf_clr is pulsed.
- R10: While cfg_run is 0 and the engine is idle, in_ready stays low and incoming data has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_run | input | 1 | Engine armed |
| cfg_base | input | ADDR_W | Byte address of table 0 |
| cfg_depth_m1 | input | 7 | Number of tables in the ring minus one |
| cfg_ents_m1 | input | 8 | Entries per table minus one |
| cfg_eof_ie | input | 1 | End-of-frame interrupt enable |
| sw_wptr | input | 8 | Software ring pointer (bit 7 = wrap flag) |
| eof_clr | input | 1 | Write-one clear of eof_sts |
| ovf_clr | input | 1 | Write-one clear of ovf_sts |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final byte of frame |
| in_ready | output | 1 | Input byte accepted |
| dreq_valid | output | 1 | Descriptor fetch request |
| dreq_addr | output | ADDR_W | Descriptor address |
| dreq_ready | input | 1 | Fetch request taken |
| drsp_valid | input | 1 | Fetched descriptor valid |
| drsp_data | input | 128 | Fetched descriptor |
| mw_valid | output | 1 | Byte write valid |
| mw_addr | output | 54 | Byte write address |
| mw_data | output | 8 | Byte write data |
| mw_ready | input | 1 | Byte write taken |
| wb_valid | output | 1 | Status write-back valid |
| wb_addr | output | ADDR_W | Address of the descriptor being updated |
| wb_count | output | 24 | Bytes stored in that descriptor |
| wb_hw | output | 2 | Completion code: 01b done, 10b truncated |
| wb_ready | input | 1 | Write-back taken |
| rd_ptr | output | 8 | Engine ring pointer |
| eof_sts | output | 1 | Sticky end-of-frame flag |
| ovf_sts | output | 1 | Sticky overflow flag |
| irq | output | 1 | End-of-frame interrupt |

## Verification
Two things are hard to reach from the ports. The first is a pointer wrap that meets a full ring. The second is truncation at the end of a table. For the first, the stimulus runs one frame per table in a four-table ring while holding the software pointer at 00h. After the fourth frame, rd_ptr reads 80h, so the ring looks full with no further setup. The next frame must then be dropped, and moving the software pointer to 80h reopens the ring so that 81h, 82h, 83h and 00h can be observed. Truncation is reached by sending a frame longer than a table's total capacity. The test then checks that the bytes beyond that capacity are drained without any write.

// File: rtl/prd_ring_pkg.sv
package prd_ring_pkg;
    localparam int PTR_W  = 8;
    localparam int IDX_W  = 7;
    localparam int ENT_W  = 8;
    localparam int LEN_W  = 24;
    localparam int DST_W  = 54;
    localparam int BYTE_W = 8;
    localparam int DESC_W = 128;

    localparam logic [1:0] HW_DONE  = 2'b01;
    localparam logic [1:0] HW_TRUNC = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_WAITD, ST_XFER, ST_WB, ST_DRAIN
    } rx_state_e;

    typedef struct packed {
        rx_state_e          st;
        logic [PTR_W-1:0]   rptr;
        logic [ENT_W-1:0]   ent;
        logic [DST_W-1:0]   dst;
        logic [LEN_W-1:0]   len;
        logic               eot;
        logic [LEN_W-1:0]   cnt;
        logic               trunc;
    } core_t;

    typedef struct packed {
        logic eof;
        logic ovf;
    } flags_t;
endpackage

// File: rtl/prd_ptr_ring.sv
module prd_ptr_ring
    import prd_ring_pkg::*;
(
    input  logic [PTR_W-1:0] rptr,
    input  logic [PTR_W-1:0] wptr,
    input  logic [IDX_W-1:0] depth_m1,
    output logic [PTR_W-1:0] nxt,
    output logic             full
);
    // Index wraps at the programmed depth; the top bit records each lap.
    always_comb begin
        if (rptr[IDX_W-1:0] == depth_m1) begin
            nxt = {~rptr[PTR_W-1], {IDX_W{1'b0}}};
        end else begin
            nxt = {rptr[PTR_W-1], rptr[IDX_W-1:0] + IDX_W'(1)};
        end
        full = (rptr[IDX_W-1:0] == wptr[IDX_W-1:0]) &&
               (rptr[PTR_W-1] != wptr[PTR_W-1]);
    end
endmodule

// File: rtl/prd_addr_gen.sv
module prd_addr_gen
    import prd_ring_pkg::*;
#(
    parameter int ADDR_W = 54
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  tbl,
    input  logic [ENT_W-1:0]  ents_m1,
    input  logic [ENT_W-1:0]  ent,
    output logic [ADDR_W-1:0] addr
);
    localparam int SLOT_W = IDX_W + ENT_W + 2;
    localparam int OFF_W  = SLOT_W + 4;

    logic [SLOT_W-1:0] slot;

    always_comb begin
        slot = SLOT_W'(tbl) * SLOT_W'({1'b0, ents_m1} + 9'd1) + SLOT_W'(ent);
        addr = base + ADDR_W'({slot, 4'b0000});
    end

    initial begin
        if (ADDR_W < OFF_W) $error("ADDR_W too small for table offsets");
    end
endmodule

// File: rtl/prd_status.sv
module prd_status
    import prd_ring_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_eof,
    input  logic clr_eof,
    input  logic set_ovf,
    input  logic clr_ovf,
    output logic eof_q,
    output logic ovf_q
);
    flags_t f_d, f_q;

    always_comb begin
        f_d     = f_q;
        f_d.eof = (f_q.eof & ~clr_eof) | set_eof;
        f_d.ovf = (f_q.ovf & ~clr_ovf) | set_ovf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign eof_q = f_q.eof;
    assign ovf_q = f_q.ovf;
endmodule

// File: rtl/prd_ring_rxdma.sv
module prd_ring_rxdma
    import prd_ring_pkg::*;
#(
    parameter int ADDR_W = 54
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_run,
    input  logic [ADDR_W-1:0]    cfg_base,
    input  logic [IDX_W-1:0]     cfg_depth_m1,
    input  logic [ENT_W-1:0]     cfg_ents_m1,
    input  logic                 cfg_eof_ie,
    input  logic [PTR_W-1:0]     sw_wptr,
    input  logic                 eof_clr,
    input  logic                 ovf_clr,
    input  logic                 in_valid,
    input  logic [BYTE_W-1:0]    in_data,
    input  logic                 in_last,
    output logic                 in_ready,
    output logic                 dreq_valid,
    output logic [ADDR_W-1:0]    dreq_addr,
    input  logic                 dreq_ready,
    input  logic                 drsp_valid,
    input  logic [DESC_W-1:0]    drsp_data,
    output logic                 mw_valid,
    output logic [DST_W-1:0]     mw_addr,
    output logic [BYTE_W-1:0]    mw_data,
    input  logic                 mw_ready,
    output logic                 wb_valid,
    output logic [ADDR_W-1:0]    wb_addr,
    output logic [LEN_W-1:0]     wb_count,
    output logic [1:0]           wb_hw,
    input  logic                 wb_ready,
    output logic [PTR_W-1:0]     rd_ptr,
    output logic                 eof_sts,
    output logic                 ovf_sts,
    output logic                 irq
);
    core_t c_d, c_q;

    logic [PTR_W-1:0]  ptr_nxt;
    logic              ring_full;
    logic [ADDR_W-1:0] ent_addr;
    logic              set_eof, set_ovf;

    // Fields of the fetched entry that this engine acts on.
    logic [DST_W-1:0] rsp_dst;
    logic [LEN_W-1:0] rsp_len;
    logic             rsp_eot;
    logic             unused_desc_bits;

    assign rsp_dst = drsp_data[53:0];
    assign rsp_len = drsp_data[87:64];
    assign rsp_eot = drsp_data[88];
    assign unused_desc_bits = ^{drsp_data[127:89], drsp_data[63:54]};

    prd_ptr_ring u_ptr (
        .rptr     (c_q.rptr),
        .wptr     (sw_wptr),
        .depth_m1 (cfg_depth_m1),
        .nxt      (ptr_nxt),
        .full     (ring_full)
    );

    prd_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .base    (cfg_base),
        .tbl     (c_q.rptr[IDX_W-1:0]),
        .ents_m1 (cfg_ents_m1),
        .ent     (c_q.ent),
        .addr    (ent_addr)
    );

    prd_status u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_eof (set_eof),
        .clr_eof (eof_clr),
        .set_ovf (set_ovf),
        .clr_ovf (ovf_clr),
        .eof_q   (eof_sts),
        .ovf_q   (ovf_sts)
    );

    logic tbl_end_held;
    logic tbl_end_rsp;
    logic beat;

    always_comb begin
        c_d          = c_q;
        set_eof      = 1'b0;
        set_ovf      = 1'b0;
        in_ready     = 1'b0;
        mw_valid     = 1'b0;
        dreq_valid   = 1'b0;
        wb_valid     = 1'b0;
        tbl_end_held = c_q.eot || (c_q.ent == cfg_ents_m1);
        tbl_end_rsp  = rsp_eot || (c_q.ent == cfg_ents_m1);
        beat         = 1'b0;

        unique case (c_q.st)
            ST_IDLE: begin
                if (cfg_run && in_valid) begin
                    if (ring_full) begin
                        set_ovf = 1'b1;
                        c_d.st  = ST_DRAIN;
                    end else begin
                        c_d.ent = '0;
                        c_d.st  = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                dreq_valid = 1'b1;
                if (dreq_ready) c_d.st = ST_WAITD;
            end
            ST_WAITD: begin
                if (drsp_valid) begin
                    c_d.dst = rsp_dst;
                    c_d.len = rsp_len;
                    c_d.eot = rsp_eot;
                    c_d.cnt = '0;
                    if (rsp_len != '0) begin
                        c_d.st = ST_XFER;
                    end else if (tbl_end_rsp) begin
                        c_d.trunc = 1'b1;
                        c_d.st    = ST_WB;
                    end else begin
                        c_d.ent = c_q.ent + ENT_W'(1);
                        c_d.st  = ST_FETCH;
                    end
                end
            end
            ST_XFER: begin
                in_ready = mw_ready;
                mw_valid = in_valid;
                beat     = in_valid && mw_ready;
                if (beat) begin
                    c_d.cnt = c_q.cnt + LEN_W'(1);
                    if (in_last) begin
                        c_d.trunc = 1'b0;
                        c_d.st    = ST_WB;
                    end else if ((c_q.cnt + LEN_W'(1)) == c_q.len) begin
                        if (tbl_end_held) begin
                            c_d.trunc = 1'b1;
                            c_d.st    = ST_WB;
                        end else begin
                            c_d.ent = c_q.ent + ENT_W'(1);
                            c_d.st  = ST_FETCH;
                        end
                    end
                end
            end
            ST_WB: begin
                wb_valid = 1'b1;
                if (wb_ready) begin
                    c_d.rptr = ptr_nxt;
                    set_eof  = 1'b1;
                    c_d.st   = c_q.trunc ? ST_DRAIN : ST_IDLE;
                end
            end
            ST_DRAIN: begin
                in_ready = 1'b1;
                if (in_valid && in_last) c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign dreq_addr = ent_addr;
    assign wb_addr   = ent_addr;
    assign mw_addr   = c_q.dst + DST_W'(c_q.cnt);
    assign mw_data   = in_data;
    assign wb_count  = c_q.cnt;
    assign wb_hw     = c_q.trunc ? HW_TRUNC : HW_DONE;
    assign rd_ptr    = c_q.rptr;
    assign irq       = eof_sts & cfg_eof_ie;
endmodule

// File: rtl/prd_ring_rxdma_chk.sv
module prd_ring_rxdma_chk #(
    parameter int ADDR_W = 54
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_run,
    input logic [6:0]        cfg_depth_m1,
    input logic              in_valid,
    input logic              mw_valid,
    input logic              dreq_valid,
    input logic              dreq_ready,
    input logic [ADDR_W-1:0] dreq_addr,
    input logic              wb_valid,
    input logic [1:0]        wb_hw,
    input logic [7:0]        rd_ptr,
    input logic              eof_sts,
    input logic              eof_clr,
    input logic              ovf_sts,
    input logic              ovf_clr
);
    p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_run |-> (rd_ptr[6:0] <= cfg_depth_m1));

    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr != $past(rd_ptr)) |->
            ((rd_ptr == $past(rd_ptr) + 8'd1) ||
             ((rd_ptr[6:0] == 7'd0) && (rd_ptr[7] != $past(rd_ptr[7])) &&
              ($past(rd_ptr[6:0]) == $past(cfg_depth_m1)))));

    p_write_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mw_valid |-> in_valid);

    p_fetch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq_valid && !dreq_ready) |=> (dreq_valid && $stable(dreq_addr)));

    p_wb_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ((wb_hw == 2'b01) || (wb_hw == 2'b10)));

    p_eof_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eof_sts) && !$past(eof_clr)) |-> eof_sts);

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovf_sts) && !$past(ovf_clr)) |-> ovf_sts);
endmodule

bind prd_ring_rxdma prd_ring_rxdma_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_run      (cfg_run),
    .cfg_depth_m1 (cfg_depth_m1),
    .in_valid     (in_valid),
    .mw_valid     (mw_valid),
    .dreq_valid   (dreq_valid),
    .dreq_ready   (dreq_ready),
    .dreq_addr    (dreq_addr),
    .wb_valid     (wb_valid),
    .wb_hw        (wb_hw),
    .rd_ptr       (rd_ptr),
    .eof_sts      (eof_sts),
    .eof_clr      (eof_clr),
    .ovf_sts      (ovf_sts),
    .ovf_clr      (ovf_clr)
);

// File: tb/prd_ring_rxdma_tb_top.sv
module prd_ring_rxdma_tb_top;
    localparam int ADDR_W = 54;
    localparam logic [ADDR_W-1:0] BASE = 54'h1000;
    localparam int ENTS = 2;
    localparam int ELEN = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n, cfg_run, cfg_eof_ie, eof_clr, ovf_clr;
    logic [ADDR_W-1:0] cfg_base;
    logic [6:0]        cfg_depth_m1;
    logic [7:0]        cfg_ents_m1, sw_wptr;
    logic              in_valid, in_last, in_ready;
    logic [7:0]        in_data;
    logic              dreq_valid, dreq_ready, drsp_valid;
    logic [ADDR_W-1:0] dreq_addr;
    logic [127:0]      drsp_data;
    logic              mw_valid, mw_ready;
    logic [53:0]       mw_addr;
    logic [7:0]        mw_data;
    logic              wb_valid, wb_ready;
    logic [ADDR_W-1:0] wb_addr;
    logic [23:0]       wb_count;
    logic [1:0]        wb_hw;
    logic [7:0]        rd_ptr;
    logic              eof_sts, ovf_sts, irq;

    prd_ring_rxdma #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_base(cfg_base),
        .cfg_depth_m1(cfg_depth_m1), .cfg_ents_m1(cfg_ents_m1),
        .cfg_eof_ie(cfg_eof_ie), .sw_wptr(sw_wptr), .eof_clr(eof_clr),
        .ovf_clr(ovf_clr), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .dreq_valid(dreq_valid),
        .dreq_addr(dreq_addr), .dreq_ready(dreq_ready), .drsp_valid(drsp_valid),
        .drsp_data(drsp_data), .mw_valid(mw_valid), .mw_addr(mw_addr),
        .mw_data(mw_data), .mw_ready(mw_ready), .wb_valid(wb_valid),
        .wb_addr(wb_addr), .wb_count(wb_count), .wb_hw(wb_hw),
        .wb_ready(wb_ready), .rd_ptr(rd_ptr), .eof_sts(eof_sts),
        .ovf_sts(ovf_sts), .irq(irq)
    );

    int n_chk = 0;
    int n_err = 0;

    // Descriptor memory model: 4 tables x 2 entries.
    logic [127:0] dmem [0:7];
    logic [ADDR_W-1:0] dq_log [0:63];
    int dq_n = 0;
    logic [53:0] wl_addr [0:63];
    logic [7:0]  wl_data [0:63];
    int wn = 0;
    int wb_n = 0;
    logic [ADDR_W-1:0] wb_a_last;
    logic [23:0]       wb_c_last;
    logic [1:0]        wb_h_last;

    function automatic logic [53:0] dst_of(input int idx);
        return 54'h10000 + 54'(idx) * 54'h100;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            drsp_valid <= 1'b0;
        end else begin
            drsp_valid <= dreq_valid && dreq_ready;
            if (dreq_valid && dreq_ready) begin
                drsp_data         <= dmem[3'((dreq_addr - BASE) >> 4)];
                dq_log[dq_n % 64] <= dreq_addr;
                dq_n              <= dq_n + 1;
            end
            if (mw_valid && mw_ready) begin
                wl_addr[wn % 64] <= mw_addr;
                wl_data[wn % 64] <= mw_data;
                wn               <= wn + 1;
            end
            if (wb_valid && wb_ready) begin
                wb_a_last <= wb_addr;
                wb_c_last <= wb_count;
                wb_h_last <= wb_hw;
                wb_n      <= wb_n + 1;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic send_frame(input int len, input logic [7:0] seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = seed + 8'(i);
            in_last  = (i == len - 1);
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        settle();
    endtask

    // Checks the writes of one frame into table tbl starting at log index w0.
    task automatic check_writes(input string req, input int w0, input int tbl,
                                input int nbytes, input logic [7:0] seed);
        int stored;
        stored = (nbytes < ENTS * ELEN) ? nbytes : ENTS * ELEN;
        chk(req, "write count", 64'(wn - w0), 64'(stored));
        for (int j = 0; j < stored; j++) begin
            chk(req, "write addr", 64'(wl_addr[(w0 + j) % 64]),
                64'(dst_of(tbl * ENTS + j / ELEN) + 54'(j % ELEN)));
            chk(req, "write data", 64'(wl_data[(w0 + j) % 64]), 64'(seed + 8'(j)));
        end
    endtask

    task automatic t_reset();
        chk("R1", "rd_ptr", 64'(rd_ptr), 64'h0);
        chk("R1", "eof_sts", 64'(eof_sts), 64'h0);
        chk("R1", "ovf_sts", 64'(ovf_sts), 64'h0);
        chk("R1", "irq", 64'(irq), 64'h0);
        chk("R1", "valids", 64'({in_ready, mw_valid, dreq_valid, wb_valid}), 64'h0);
    endtask

    task automatic t_run_off();
        int w0;
        w0 = wn;
        @(negedge clk);
        cfg_run  = 1'b0;
        in_valid = 1'b1;
        in_last  = 1'b1;
        in_data  = 8'hAA;
        repeat (6) @(negedge clk);
        #1;
        chk("R10", "in_ready while off", 64'(in_ready), 64'h0);
        chk("R10", "writes while off", 64'(wn - w0), 64'h0);
        chk("R10", "rd_ptr while off", 64'(rd_ptr), 64'h0);
        in_valid = 1'b0;
        in_last  = 1'b0;
        cfg_run  = 1'b1;
        settle();
    endtask

    task automatic t_short();
        int w0;
        w0 = wn;
        cfg_eof_ie = 1'b0;
        send_frame(3, 8'h10);
        check_writes("R3", w0, 0, 3, 8'h10);
        chk("R6", "wb addr", 64'(wb_a_last), 64'(BASE));
        chk("R6", "wb count", 64'(wb_c_last), 64'd3);
        chk("R6", "wb code", 64'(wb_h_last), 64'b01);
        chk("R7", "rd_ptr after frame", 64'(rd_ptr), 64'h01);
        chk("R7", "eof set", 64'(eof_sts), 64'h1);
        chk("R8", "irq masked", 64'(irq), 64'h0);
        cfg_eof_ie = 1'b1;
        #1;
        chk("R8", "irq enabled", 64'(irq), 64'h1);
        @(negedge clk);
        chk("R7", "eof held", 64'(eof_sts), 64'h1);
        eof_clr = 1'b1;
        @(negedge clk);
        eof_clr = 1'b0;
        chk("R7", "eof cleared", 64'(eof_sts), 64'h0);
        chk("R8", "irq after clear", 64'(irq), 64'h0);
    endtask

    task automatic t_span();
        int w0, d0;
        w0 = wn;
        d0 = dq_n;
        send_frame(6, 8'h40);
        check_writes("R6", w0, 1, 6, 8'h40);
        chk("R2", "fetch count", 64'(dq_n - d0), 64'd2);
        chk("R2", "first fetch", 64'(dq_log[d0 % 64]), 64'(BASE + 54'h20));
        chk("R2", "second fetch", 64'(dq_log[(d0 + 1) % 64]), 64'(BASE + 54'h30));
        chk("R6", "wb addr", 64'(wb_a_last), 64'(BASE + 54'h30));
        chk("R6", "wb count", 64'(wb_c_last), 64'd2);
        chk("R6", "wb code", 64'(wb_h_last), 64'b01);
        chk("R4", "rd_ptr", 64'(rd_ptr), 64'h02);
    endtask

    task automatic t_trunc();
        int w0;
        w0 = wn;
        send_frame(11, 8'h70);
        check_writes("R5", w0, 2, 11, 8'h70);
        chk("R5", "wb addr", 64'(wb_a_last), 64'(BASE + 54'h50));
        chk("R5", "wb count", 64'(wb_c_last), 64'd4);
        chk("R5", "wb code", 64'(wb_h_last), 64'b10);
        chk("R4", "rd_ptr", 64'(rd_ptr), 64'h03);
    endtask

    task automatic t_wrap_full();
        int w0, b0;
        send_frame(1, 8'h01);
        chk("R4", "rollover", 64'(rd_ptr), 64'h80);
        w0 = wn;
        b0 = wb_n;
        send_frame(3, 8'h90);
        chk("R9", "drop writes", 64'(wn - w0), 64'h0);
        chk("R9", "drop wb", 64'(wb_n - b0), 64'h0);
        chk("R9", "drop rd_ptr", 64'(rd_ptr), 64'h80);
        chk("R9", "ovf set", 64'(ovf_sts), 64'h1);
        @(negedge clk);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk("R9", "ovf cleared", 64'(ovf_sts), 64'h0);
        sw_wptr = 8'h80;
        w0 = wn;
        send_frame(1, 8'h05);
        chk("R4", "table 0 reused", 64'(wl_addr[w0 % 64]), 64'(dst_of(0)));
        chk("R4", "seq 81", 64'(rd_ptr), 64'h81);
        send_frame(1, 8'h06);
        chk("R4", "seq 82", 64'(rd_ptr), 64'h82);
        send_frame(1, 8'h07);
        chk("R4", "seq 83", 64'(rd_ptr), 64'h83);
        send_frame(1, 8'h08);
        chk("R4", "seq 00", 64'(rd_ptr), 64'h00);
    endtask

    initial begin
        for (int t = 0; t < 4; t++) begin
            for (int k = 0; k < ENTS; k++) begin
                dmem[t * ENTS + k] = '0;
                dmem[t * ENTS + k][53:0]  = dst_of(t * ENTS + k);
                dmem[t * ENTS + k][87:64] = 24'(ELEN);
                dmem[t * ENTS + k][88]    = (k == ENTS - 1);
            end
        end
        rst_n = 1'b0; cfg_run = 1'b1; cfg_eof_ie = 1'b0; eof_clr = 1'b0;
        ovf_clr = 1'b0; cfg_base = BASE; cfg_depth_m1 = 7'd3;
        cfg_ents_m1 = 8'(ENTS - 1); sw_wptr = 8'h00;
        in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
        dreq_ready = 1'b1; mw_ready = 1'b1; wb_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_run_off();
        t_short();
        t_span();
        t_trunc();
        t_wrap_full();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule